// File: doc/BRIEF.md
# Burst-of-Four DDR Read Sequencer

This block drives the read half of a burst-of-four double-data-rate static memory port. It runs on a beat clock at twice the interface rate. An internal phase bit tells each beat-clock edge apart as either a main-clock (K) rising slot or a complementary-clock (K#) rising slot. A read request is an active-low strobe plus a burst address, sampled only in K slots. Some fixed number of half-cycles later, the block returns four data words on its output, one per slot. It also drives a data-valid flag and a pair of free-running echo strobes.

Array words come from a plain synchronous memory port with one slot of read latency. The block supplies the full word address, which is the burst address with two beat bits appended below it. A mode input selects between two latencies: the normal one of 2.5 cycles, and a bypass one of one cycle. Commands must be spaced at least two K cycles apart. A command that arrives one K cycle after an accepted read is dropped and flagged.

Top module: `burst4_rd_seq`

## Requirements
- R1: A read is accepted only on a K-slot edge (`k_rise_slot` high before the edge) at which `rd_n` is low, and `rd_addr` is captured on that edge. A low `rd_n` at a K#-slot edge has no effect. The first edge after reset release is a K slot, and slots alternate from then on.
- R2: With `dll_off` low, the four beats of a read accepted at edge E appear on `q` after edges E+5, E+6, E+7 and E+8, so the first beat lands on a K# slot. `q` reads zero in every slot that carries no beat.
- R3: Beat b (b = 0..3) carries the memory word at address `{rd_addr, b}`, with b in the two low bits. The memory port is read with `mem_re` in the slot two edges before that beat appears.
- R4: K slots with `rd_n` high are idle and do not shorten a burst that is already in flight.
- R5: A low `rd_n` at the K slot that directly follows an accepted read is ignored: it produces no beats and no valid flag. `rd_err` is high for exactly the one slot after that edge.
- R6: `q_valid` is high after edge e exactly when beats are due after both edge e+1 and edge e+2. For a lone read at E this means high after E+4, E+5 and E+6, and low again after E+7, one slot before the last beat.
- R7: Reads accepted at E and E+4 produce eight consecutive beats, and `q_valid` stays high without a gap from E+4 through E+10.
- R8: `cq` is high after every K-slot edge and low after every K#-slot edge, and `cq_n` is its complement. Both keep toggling while no read is active.
- R9: With `dll_off` high, the beats of a read accepted at E appear after edges E+2 to E+5, and `q_valid` is high after E+1 to E+3.
- R10: During reset `q`, `q_valid`, `rd_err` and `mem_re` are zero, and `k_rise_slot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Beat clock, two edges per interface cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| dll_off | input | 1 | High selects the one-cycle latency mode; change only while idle |
| rd_n | input | 1 | Active-low read command |
| rd_addr | input | BA_W | Burst address |
| k_rise_slot | output | 1 | High when the coming edge is a K-slot edge |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | BA_W+2 | Memory word address |
| mem_rdata | input | DATA_W | Memory read data, one slot after `mem_re` |
| q | output | DATA_W | Read data beats |
| q_valid | output | 1 | Data-valid flag, leading the burst by one slot |
| cq | output | 1 | Echo strobe, high after K slots |
| cq_n | output | 1 | Complementary echo strobe |
| rd_err | output | 1 | One-slot pulse for a command dropped by the spacing rule |

## Verification
A wrong phase bit moves every beat and echo edge by one slot. The first cycle after reset already shows this on `cq` and `k_rise_slot`. A fault in the delay line or the beat counter shows up five slots after a command, when a word comes out at the wrong time, out of order, or with the wrong address. A spacing register that fails to clear drops the next legal read, which is seen at its first missing beat. A spacing register that fails to set gives a missing `rd_err` and a run of extra beats. Errors in the valid look-ahead appear as a flag that is one slot off at either end of a burst, or as a one-slot hole between back-to-back bursts.

// File: rtl/b4rs_pkg.sv
package b4rs_pkg;
  // beat index width within one burst of four
  localparam int BEAT_W = 2;
  localparam logic [BEAT_W-1:0] LAST_BEAT = 2'b11;
  // half-cycle latency from command edge to first beat, per mode
  localparam int LAT_HALF_NORM   = 5;
  localparam int LAT_HALF_BYPASS = 2;
  // half-cycles spent between mem_re and the beat on q
  localparam int RET_HALF = 2;

  // number of registered stages the normal-mode command waits before issue
  function automatic int lead_stages(input int lat_half);
    return lat_half - RET_HALF;
  endfunction

  // beat counter advance inside one burst
  function automatic logic [BEAT_W-1:0] beat_step(input logic [BEAT_W-1:0] b);
    return b + 1'b1;
  endfunction
endpackage

// File: rtl/b4rs_gate.sv
module b4rs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  output logic k_edge,
  output logic acc_now,
  output logic cmd_v,
  output logic rd_err
);
  logic recent;
  logic rej_now;

  always_comb begin
    acc_now = k_edge && !rd_n && !recent;
    rej_now = k_edge && !rd_n && recent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_edge <= 1'b1;
      recent <= 1'b0;
      cmd_v  <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      k_edge <= !k_edge;
      cmd_v  <= acc_now;
      rd_err <= rej_now;
      if (k_edge) recent <= acc_now;
    end
  end

  // R1: accepted commands sit on K slots, so two in a row are impossible
  p_k_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |=> !cmd_v);
  // R5: a rejection is always one K cycle after an acceptance
  p_err_after_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(cmd_v, 2));
  // R5: a rejection never coincides with an acceptance
  p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_err && cmd_v));
endmodule

// File: rtl/b4rs_issue.sv
module b4rs_issue #(
  parameter int BA_W = 19,
  parameter int LEAD = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dll_off,
  input  logic                              acc_now,
  input  logic [BA_W-1:0]                   acc_addr,
  output logic                              mem_re,
  output logic [BA_W+b4rs_pkg::BEAT_W-1:0]  mem_addr,
  output logic                              act_next
);
  import b4rs_pkg::*;

  logic [LEAD-1:0] dv;
  logic [BA_W-1:0] da [LEAD];

  // delay line of accepted commands for the normal latency
  generate
    for (genvar s = 0; s < LEAD; s++) begin : g_dly
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            dv[0] <= 1'b0;
            da[0] <= '0;
          end else begin
            dv[0] <= acc_now;
            da[0] <= acc_addr;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            dv[s] <= 1'b0;
            da[s] <= '0;
          end else begin
            dv[s] <= dv[s-1];
            da[s] <= da[s-1];
          end
        end
      end
    end
  endgenerate

  function automatic logic [BA_W+BEAT_W-1:0] word_addr(input logic [BA_W-1:0] base,
                                                       input logic [BEAT_W-1:0] b);
    return {base, b};
  endfunction

  logic              start;
  logic [BA_W-1:0]   start_addr;
  logic              act;
  logic [BEAT_W-1:0] beat, beat_nx;
  logic [BA_W-1:0]   base, base_nx;

  always_comb begin
    start      = dll_off ? acc_now  : dv[LEAD-1];
    start_addr = dll_off ? acc_addr : da[LEAD-1];
    act_next   = act;
    beat_nx    = beat;
    base_nx    = base;
    if (start) begin
      act_next = 1'b1;
      beat_nx  = '0;
      base_nx  = start_addr;
    end else if (act) begin
      beat_nx  = beat_step(beat);
      act_next = (beat != LAST_BEAT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      beat <= '0;
      base <= '0;
    end else begin
      act  <= act_next;
      beat <= beat_nx;
      base <= base_nx;
    end
  end

  assign mem_re   = act;
  assign mem_addr = word_addr(base, beat);

  // R3: a burst reads four consecutive word addresses without a break
  p_burst_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr[BEAT_W-1:0] != LAST_BEAT) |=>
      (mem_re && mem_addr[BEAT_W-1:0] == $past(mem_addr[BEAT_W-1:0]) + 1'b1));
  // R4/R7: a new burst never cuts into one still being issued
  p_no_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!act || beat == LAST_BEAT));
endmodule

// File: rtl/b4rs_beat.sv
module b4rs_beat #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_edge,
  input  logic              mem_re,
  input  logic              act_next,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] q,
  output logic              q_valid,
  output logic              cq,
  output logic              cq_n
);
  logic data_ok;
  logic q_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_ok <= 1'b0;
      q_live  <= 1'b0;
      q       <= '0;
      q_valid <= 1'b0;
      cq      <= 1'b0;
      cq_n    <= 1'b1;
    end else begin
      data_ok <= mem_re;
      q_live  <= data_ok;
      q       <= data_ok ? mem_rdata : '0;
      // a beat is due after the next edge and after the one after it
      q_valid <= mem_re && act_next;
      cq      <= k_edge;
      cq_n    <= !k_edge;
    end
  end

  // R6: the flag always announces a beat one slot ahead
  p_valid_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> q_live);
  // R2: idle slots carry zero data
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_live |-> (q == '0));
  // R8: echo strobe toggles every slot
  p_echo_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cq && $past(rst_n)) |=> !cq);
  p_echo_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cq && $past(rst_n)) |=> cq);
endmodule

// File: rtl/burst4_rd_seq.sv
module burst4_rd_seq #(
  parameter int BA_W   = 19,
  parameter int DATA_W = 36
) (
  input  logic                  clk2x,
  input  logic                  rst_n,
  input  logic                  dll_off,
  input  logic                  rd_n,
  input  logic [BA_W-1:0]       rd_addr,
  output logic                  k_rise_slot,
  output logic                  mem_re,
  output logic [BA_W+1:0]       mem_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [DATA_W-1:0]     q,
  output logic                  q_valid,
  output logic                  cq,
  output logic                  cq_n,
  output logic                  rd_err
);
  import b4rs_pkg::*;

  localparam int LEAD = lead_stages(LAT_HALF_NORM);

  logic k_edge;
  logic acc_now;
  logic cmd_v;
  logic act_next;

  b4rs_gate u_gate (
    .clk     (clk2x),
    .rst_n   (rst_n),
    .rd_n    (rd_n),
    .k_edge  (k_edge),
    .acc_now (acc_now),
    .cmd_v   (cmd_v),
    .rd_err  (rd_err)
  );

  b4rs_issue #(.BA_W(BA_W), .LEAD(LEAD)) u_issue (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .dll_off  (dll_off),
    .acc_now  (acc_now),
    .acc_addr (rd_addr),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .act_next (act_next)
  );

  b4rs_beat #(.DATA_W(DATA_W)) u_beat (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .k_edge    (k_edge),
    .mem_re    (mem_re),
    .act_next  (act_next),
    .mem_rdata (mem_rdata),
    .q         (q),
    .q_valid   (q_valid),
    .cq        (cq),
    .cq_n      (cq_n)
  );

  assign k_rise_slot = k_edge;

  // R9: in bypass mode the first memory read follows the command edge directly
  p_bypass_issue_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
    (dll_off && cmd_v) |-> mem_re);
  // R2: in normal mode the first memory read waits three slots
  p_norm_issue_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    (!dll_off && cmd_v) |=> ##2 mem_re);
endmodule

// File: tb/test_burst4_rd_seq.sv
module test_burst4_rd_seq;
  localparam int BA = 8;
  localparam int DW = 36;
  localparam int NE = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dll_off = 1'b0;
  logic rd_n = 1'b1;
  logic [BA-1:0] rd_addr = '0;
  logic k_rise_slot, mem_re, q_valid, cq, cq_n, rd_err;
  logic [BA+1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] q;

  always #2.5 clk = ~clk;

  burst4_rd_seq #(.BA_W(BA), .DATA_W(DW)) i_burst4_rd_seq (
    .clk2x(clk), .rst_n(rst_n), .dll_off(dll_off), .rd_n(rd_n), .rd_addr(rd_addr),
    .k_rise_slot(k_rise_slot), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .q(q), .q_valid(q_valid), .cq(cq), .cq_n(cq_n),
    .rd_err(rd_err));

  function automatic logic [DW-1:0] model(input int wa);
    logic [DW-1:0] v;
    v = DW'(wa) * DW'(40503) ^ DW'(36'h5A5A5A5A5);
    return v;
  endfunction

  always @(posedge clk) mem_rdata <= mem_re ? model(int'(mem_addr)) : '0;

  typedef struct { int at; logic [DW-1:0] data; string req; } item_t;
  item_t sb[$];
  bit exp_beat [NE];
  bit exp_err  [NE];
  bit acc_at   [NE];
  int edge_no = -1;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  string cur_req = "R6";

  always @(posedge clk) if (rst_n) edge_no <= edge_no + 1;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s at edge %0d: actual %h expected %h", r, what, edge_no, act, exp);
    end
  endtask

  // driver: command on the next K slot, scoreboard fed from the requirements
  task automatic cmd(input logic [BA-1:0] a, input string r);
    int e, lat;
    do @(negedge clk); while (k_rise_slot !== 1'b1);
    rd_n = 1'b0; rd_addr = a;
    e = edge_no + 1;
    if (e >= 2 && acc_at[e-2]) exp_err[e] = 1'b1;
    else begin
      acc_at[e] = 1'b1;
      lat = dll_off ? 2 : 5;
      for (int b = 0; b < 4; b++) begin
        item_t it;
        exp_beat[e+lat+b] = 1'b1;
        it.at = e + lat + b; it.data = model(int'(a) * 4 + b); it.req = r;
        sb.push_back(it);
      end
    end
    @(negedge clk); rd_n = 1'b1; rd_addr = ~a;
  endtask

  // strobe low only across a K# slot edge
  task automatic cmd_on_kbar(input logic [BA-1:0] a);
    do @(negedge clk); while (k_rise_slot !== 1'b0);
    rd_n = 1'b0; rd_addr = a;
    @(negedge clk); rd_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && edge_no >= 0 && !done) begin
        int n;
        n = edge_no;
        if (sb.size() > 0 && sb[0].at < n) begin
          chk(1'b0, sb[0].req, "missed beat", 64'(sb[0].at), 64'(n));
          void'(sb.pop_front());
        end
        if (sb.size() > 0 && sb[0].at == n) begin
          chk(q == sb[0].data, sb[0].req, "beat data R3", 64'(q), 64'(sb[0].data));
          void'(sb.pop_front());
        end else
          chk(q == '0, "R2", "idle q", 64'(q), 64'd0);
        chk(q_valid == (exp_beat[n+1] && exp_beat[n+2]), cur_req, "q_valid",
            64'(q_valid), 64'(exp_beat[n+1] && exp_beat[n+2]));
        chk(rd_err == exp_err[n], "R5", "rd_err", 64'(rd_err), 64'(exp_err[n]));
        chk(cq == (n % 2 == 0) && cq_n == !(n % 2 == 0), "R8", "echo",
            64'({cq, cq_n}), 64'({n % 2 == 0, n % 2 != 0}));
        chk(k_rise_slot == ((n + 1) % 2 == 0), "R1", "slot phase",
            64'(k_rise_slot), 64'((n + 1) % 2 == 0));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(q == '0 && !q_valid && !rd_err && !mem_re, "R10", "outputs in reset",
        64'({q_valid, rd_err, mem_re}), 64'd0);
    chk(k_rise_slot == 1'b1, "R10", "phase in reset", 64'(k_rise_slot), 64'd1);
    rst_n = 1'b1;
    idle(6);                     // R8: echo keeps toggling while idle
    cur_req = "R6";
    cmd(8'h05, "R2");            // R1/R2/R3/R6 lone read, R4 idle slots follow
    idle(14);
    cmd_on_kbar(8'h11);          // R1: K# slot command ignored
    idle(14);
    cur_req = "R5";
    cmd(8'h20, "R5");
    cmd(8'h21, "R5");            // R5: one K cycle later, dropped
    idle(14);
    cur_req = "R7";
    cmd(8'h30, "R7");
    idle(1);
    cmd(8'h31, "R7");            // R7: accepted four slots later
    idle(18);
    cmd(8'hFF, "R3");            // R3: top burst address
    idle(14);
    dll_off = 1'b1;
    cur_req = "R9";
    cmd(8'h42, "R9");            // R9: bypass latency
    idle(10);
    cmd(8'h43, "R9");
    idle(1);
    cmd(8'h44, "R9");
    idle(14);
    dll_off = 1'b0;
    cur_req = "R4";
    cmd(8'h55, "R4");            // R4: burst runs out through idle K slots
    idle(16);
    chk(sb.size() == 0, "R2", "scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule